// File: doc/BRIEF.md
# Pointer-Addressed Mailbox Port

This block gives a host byte-wide access to a local buffer memory through four small port selects. A 16-bit address pointer is loaded by the host one byte at a time, low half first. One data port moves bytes with post-increment of the pointer, so a whole block can be written or read as a back-to-back burst. A second data port reads the byte under the pointer and leaves the pointer where it is, so the host can poll one response location repeatedly.

Commands go to an attached engine by writing a command byte to a strobe port. The block accepts the strobe only while its ready flag is set, and the host reads that flag from a status port. A built-in stub responder stands in for the engine. A fixed number of cycles after each accepted strobe, it writes a completion byte over the response location, and the ready flag comes back on that same clock edge. The host's normal sequence is: preset the response byte to 0xFF, strobe, then poll until the byte is no longer 0xFF. Received data is read as 256-byte bursts starting at pointer 0x0400.

Top module: `ptr_mailbox`

## Requirements
- R1: After reset the pointer is 0x0000, the ready flag is 1 and no strobe is pulsed.
- R2: A write with select 1 loads pointer bits 7:0, and a write with select 3 loads pointer bits 15:8. The host loads the low half first, so writing 0x00 to both gives 0x0000.
- R3: A write with select 0 stores the byte at the pointer, and the pointer then advances by one.
- R4: A read with select 0 returns the byte at the pointer, and the pointer advances by one at the following clock edge.
- R5: A read with select 2 returns the byte at the pointer and leaves the pointer unchanged.
- R6: A write with select 2 while ready is 1 is accepted. On the next cycle it drives `eng_strobe` high for exactly one cycle, puts the written value on `eng_cmd`, and shows ready as 0 in that same cycle.
- R7: A write with select 2 while ready is 0 is ignored. No strobe pulses and the command in progress is unchanged.
- R8: A read with select 3 returns the status byte: bit 7 is the ready flag and bits 6:0 read 0. A read with select 1 returns 0x00.
- R9: RESP_DELAY clock edges after the edge that accepts a strobe, the responder writes {0, cmd[6:0]} to pointer address RESP_ADDR (default 0x0000), and ready returns to 1 on that same edge.
- R10: The pointer wraps from 0xFFFF to 0x0000 when it advances. Only its low AW bits (default 11) address the RAM, so 0xFFFF aliases 0x07FF and 0x0800 aliases 0x0000.
- R11: After 256 bytes are written from pointer 0x0400 and the pointer is reloaded to 0x0400, 256 reads with select 0 return the same bytes in order and leave the pointer at 0x0500.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Port select: 0 burst data, 1 pointer low / zero read, 2 poll data / strobe, 3 pointer high / status |
| host_wr | input | 1 | Host write enable for the selected port |
| host_rd | input | 1 | Host read enable; causes the read side effect on select 0 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte for the selected port, valid in the same cycle |
| eng_strobe | output | 1 | One-cycle command strobe to the engine |
| eng_cmd | output | 8 | Command byte of the last accepted strobe |

## Verification
The assertions check on every cycle how the pointer moves: one step for each burst-port access and no step for a poll read. They also check that a strobe pulse lasts exactly one cycle, carries the written value and clears ready, and that a strobe written while busy never produces a pulse. Only the bench scenarios can show what is stored in the RAM: the byte order of a 256-byte burst, aliasing and wrap of the pointer, the response value left by the stub, and the exact count of cycles before ready returns.

// File: rtl/ptr_mailbox.sv
module ptr_mailbox #(
  parameter int AW = 11,
  parameter int RESP_DELAY = 4,
  parameter logic [15:0] RESP_ADDR = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       eng_strobe,
  output logic [7:0] eng_cmd
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(RESP_DELAY + 1);
  localparam logic [AW-1:0] RESP_IDX = RESP_ADDR[AW-1:0];

  logic [7:0]    mem [DEPTH];
  logic [15:0]   ptr;
  logic          ready;
  logic [CW-1:0] cnt;

  wire [AW-1:0] idx       = ptr[AW-1:0];
  wire          data_wr   = host_wr && host_sel == 2'd0;
  wire          data_rd   = host_rd && !host_wr && host_sel == 2'd0;
  wire          strobe_ok = host_wr && host_sel == 2'd2 && ready;
  wire          resp_fire = !ready && cnt == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= 16'h0000;
    else if (host_wr && host_sel == 2'd1)
      ptr[7:0] <= host_wdata;
    else if (host_wr && host_sel == 2'd3)
      ptr[15:8] <= host_wdata;
    else if (data_wr || data_rd)
      ptr <= ptr + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready      <= 1'b1;
      cnt        <= '0;
      eng_strobe <= 1'b0;
      eng_cmd    <= 8'h00;
    end else begin
      eng_strobe <= strobe_ok;
      if (strobe_ok) begin
        ready   <= 1'b0;
        cnt     <= CW'(RESP_DELAY);
        eng_cmd <= host_wdata;
      end else if (resp_fire) begin
        ready <= 1'b1;
        cnt   <= '0;
      end else if (!ready) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (resp_fire)
      mem[RESP_IDX] <= {1'b0, eng_cmd[6:0]};
    else if (data_wr)
      mem[idx] <= host_wdata;
  end

  always_comb begin
    case (host_sel)
      2'd1:    host_rdata = 8'h00;
      2'd3:    host_rdata = {ready, 7'b0};
      default: host_rdata = mem[idx];
    endcase
  end
endmodule

// File: rtl/ptr_mailbox_chk.sv
module ptr_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  host_sel,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_wdata,
  input logic        eng_strobe,
  input logic [7:0]  eng_cmd,
  input logic [15:0] ptr,
  input logic        ready
);
  p_burst_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd0) |=> ptr == $past(ptr) + 16'd1);

  p_burst_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == 2'd0) |=> ptr == $past(ptr) + 16'd1);

  p_poll_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel == 2'd2) |=> ptr == $past(ptr));

  p_strobe_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd2 && ready) |=>
      (eng_strobe && !ready && eng_cmd == $past(host_wdata)));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_strobe |=> !eng_strobe);

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd2 && !ready) |=> !eng_strobe);
endmodule

bind ptr_mailbox ptr_mailbox_chk chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .eng_strobe(eng_strobe),
  .eng_cmd(eng_cmd), .ptr(ptr), .ready(ready)
);

// File: tb/ptr_mailbox_test.sv
`timescale 1ns/1ps
module ptr_mailbox_test;
  localparam int DLY = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sel = 2'd3;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata, cmd;
  logic strobe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptr_mailbox #(.AW(11), .RESP_DELAY(DLY), .RESP_ADDR(16'h0000)) uut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_wr(wr), .host_rd(rd),
    .host_wdata(wd), .host_rdata(rdata), .eng_strobe(strobe), .eng_cmd(cmd));

  // {sel[20:19], wr[18], rd[17], wdata[16:9], expected[8:1], check[0]}
  // R2 pointer loads, R3 burst writes, R5 poll reads, R4 burst reads, R8 status
  localparam logic [20:0] VEC [14] = '{
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {2'd3, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0},
    {2'd0, 1'b1, 1'b0, 8'hA1, 8'h00, 1'b0},
    {2'd0, 1'b1, 1'b0, 8'hB2, 8'h00, 1'b0},
    {2'd0, 1'b1, 1'b0, 8'hC3, 8'h00, 1'b0},
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'hA1, 1'b1},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'hA1, 1'b1},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hA1, 1'b1},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hB2, 1'b1},
    {2'd2, 1'b0, 1'b1, 8'h00, 8'hC3, 1'b1},
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hC3, 1'b1},
    {2'd3, 1'b0, 1'b1, 8'h00, 8'h80, 1'b1},
    {2'd1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic hop(logic [1:0] s, logic w, logic r, logic [7:0] d);
    @(negedge clk);
    sel = s; wr = w; rd = r; wd = d;
    #1;
  endtask

  task automatic setp(logic [15:0] p);
    hop(2'd1, 1'b1, 1'b0, p[7:0]);
    hop(2'd3, 1'b1, 1'b0, p[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    hop(2'd3, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 status", rdata, 8'h80);
    check("R1 strobe", {7'b0, strobe}, 8'h00);
    hop(2'd1, 1'b1, 1'b0, 8'h00);
    hop(2'd0, 1'b1, 1'b0, 8'h3C);
    setp(16'h0000);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R1 pointer at 0", rdata, 8'h3C);

    for (int i = 0; i < 14; i++) begin
      hop(VEC[i][20:19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      if (VEC[i][0]) check($sformatf("R4 R5 R8 vector %0d", i), rdata, VEC[i][8:1]);
    end

    // R6 / R9: accepted strobe and response timing
    setp(16'h0000);
    hop(2'd0, 1'b1, 1'b0, 8'hFF);
    hop(2'd2, 1'b1, 1'b0, 8'hB5);
    hop(2'd3, 1'b0, 1'b0, 8'h00);
    check("R6 strobe high", {7'b0, strobe}, 8'h01);
    check("R6 command", cmd, 8'hB5);
    check("R6 ready low", rdata, 8'h00);
    k = 0;
    while (rdata != 8'h80 && k < 100) begin
      hop(2'd3, 1'b0, 1'b0, 8'h00);
      if (k == 0) check("R6 strobe one cycle", {7'b0, strobe}, 8'h00);
      k++;
    end
    check("R9 ready latency", 8'(k), 8'(DLY));
    setp(16'h0000);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R9 response byte", rdata, 8'h35);

    // R7: strobe while busy is ignored
    hop(2'd0, 1'b1, 1'b0, 8'hFF);
    hop(2'd2, 1'b1, 1'b0, 8'h12);
    hop(2'd2, 1'b1, 1'b0, 8'h44);
    hop(2'd3, 1'b0, 1'b0, 8'h00);
    check("R7 no strobe", {7'b0, strobe}, 8'h00);
    check("R7 command kept", cmd, 8'h12);
    k = 0;
    while (rdata != 8'h80 && k < 100) begin
      hop(2'd3, 1'b0, 1'b0, 8'h00);
      k++;
    end
    setp(16'h0000);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R7 response from first command", rdata, 8'h12);

    // R10: wrap and aliasing
    setp(16'hFFFF);
    hop(2'd0, 1'b1, 1'b0, 8'h5A);
    hop(2'd0, 1'b1, 1'b0, 8'h66);
    setp(16'h0000);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R10 wrap to 0000", rdata, 8'h66);
    setp(16'h07FF);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R10 alias 07FF", rdata, 8'h5A);
    setp(16'h0800);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R10 alias 0800", rdata, 8'h66);

    // R11: 256-byte burst at 0x0400
    setp(16'h0500);
    hop(2'd0, 1'b1, 1'b0, 8'hE7);
    setp(16'h0400);
    for (int i = 0; i < 256; i++) hop(2'd0, 1'b1, 1'b0, 8'(i) ^ 8'h5C);
    setp(16'h0400);
    for (int i = 0; i < 256; i++) begin
      hop(2'd0, 1'b0, 1'b1, 8'h00);
      if (rdata !== (8'(i) ^ 8'h5C)) check($sformatf("R11 byte %0d", i), rdata, 8'(i) ^ 8'h5C);
    end
    check("R11 burst sample", 8'h00, 8'h00);
    hop(2'd2, 1'b0, 1'b1, 8'h00);
    check("R11 pointer at 0500", rdata, 8'hE7);

    hop(2'd3, 1'b0, 1'b0, 8'h00);
    finish_run();
  end
endmodule